// File: doc/BRIEF.md
# Word ECC Read-Modify-Write Unit

This unit sits between a byte-addressed request port and a storage array whose words are 38 bits wide. Every stored word holds four data bytes and six Hamming check bits. A read request recomputes the syndrome of the stored word, corrects any single flipped bit, and returns the requested byte. A write that covers all four byte lanes is encoded and stored directly. A write that covers fewer lanes first fetches and corrects the stored word, merges the new lanes into it, re-encodes, and stores all 38 bits. A one-byte write therefore rewrites the whole word and its check bits.

Requests use a valid/ready handshake. Ready is high only while the unit is idle, so one request is in flight at a time. Read data comes back on a single-cycle response strobe. The array port is a single-port synchronous memory interface with one cycle of read latency.

Top module: `ecc_rmw_unit`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and arr_en are 0.
- R2: The stored codeword uses Hamming positions 1..38, with position p held in array bit p-1. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the remaining positions in ascending order. Check bit 2^k gives even parity over every position whose index has bit k set.
- R3: A write with mask 4'b1111 performs no array read. It performs exactly one array write, in the first cycle after acceptance, and req_ready is low for that one cycle only.
- R4: A write with any other mask reads the word in the first cycle after acceptance and writes it back in the third cycle. req_ready is low for three cycles. Each lane i with mask bit i set takes req_wdata[8i+7:8i]. Each other lane keeps its stored value.
- R5: A read returns lane req_addr[1:0] of word req_addr[13:2] on rsp_data. rsp_valid is high for one cycle, in the third cycle after acceptance. There is one array read and no array write, and req_ready is low for two cycles.
- R6: A single flipped bit at any of the 32 data positions of a stored word is corrected in the returned byte.
- R7: A single flipped bit at a check position leaves the returned byte unchanged.
- R8: A partial write stores a codeword with zero syndrome. This holds even when the stored word held a single-bit error before the write, so the error is removed.
- R9: A write with mask 4'b0000 still runs the read-merge-write sequence and rewrites the corrected word with its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address: bits 13:2 word, bits 1:0 lane |
| req_mask | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| rsp_valid | output | 1 | Read byte valid (one cycle) |
| rsp_data | output | 8 | Corrected read byte |
| arr_en | output | 1 | Array access this cycle |
| arr_we | output | 1 | Array access is a write |
| arr_addr | output | 12 | Array word address |
| arr_wdata | output | 38 | Codeword to store |
| arr_rdata | input | 38 | Codeword read, valid one cycle after a read access |

## Verification
Take the acceptance edge as edge 0. A full write is on the array port in the cycle after edge 0 and ready returns after edge 1. A read issues its array access after edge 0, corrects after edge 1, and raises rsp_valid after edge 2. A partial write reads after edge 0, merges after edge 1, and drives the array write after edge 2. The bench samples on falling edges and counts falling edges from acceptance. It checks the cycle in which rsp_valid first appears and the number of cycles ready stays low, and counts array reads and writes in its own memory model. It also compares stored codewords against a codeword it builds from the R2 layout.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_FIX, ST_WRITE} rmw_state_e;

  // Spread data bits over the non-power-of-two positions.
  function automatic logic [CW_W-1:0] ecc_place(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    int j;
    cw = '0;
    j  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[j];
        j++;
      end
    end
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(input logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = cw[p-1];
        j++;
      end
    end
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] ecc_syndrome(input logic [CW_W-1:0] cw);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (cw[p-1]) s = s ^ CHK_W'(p);
    end
    return s;
  endfunction

  function automatic logic [CW_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0]  cw;
    logic [CHK_W-1:0] s;
    cw = ecc_place(d);
    s  = ecc_syndrome(cw);
    for (int k = 0; k < CHK_W; k++) cw[(1 << k) - 1] = s[k];
    return cw;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  assign cw_o = ecc_encode(data_i);
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o
);
  logic [CHK_W-1:0] syn;
  logic [CW_W-1:0]  fixed_cw;

  always_comb begin
    syn      = ecc_syndrome(cw_i);
    fixed_cw = cw_i;
    if (syn != '0 && int'(syn) <= CW_W) fixed_cw[int'(syn) - 1] = ~cw_i[int'(syn) - 1];
    data_o   = ecc_extract(fixed_cw);
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import ecc_pkg::*;
(
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*BYTE_W +: BYTE_W] = mask_i[l] ? new_i[l*BYTE_W +: BYTE_W]
                                                    : old_i[l*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ecc_rmw_unit.sv
module ecc_rmw_unit
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [LANES-1:0]            req_mask,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic [BYTE_W-1:0]           rsp_data,
  output logic                        arr_en,
  output logic                        arr_we,
  output logic [ADDR_W-$clog2(LANES)-1:0] arr_addr,
  output logic [CW_W-1:0]             arr_wdata,
  input  logic [CW_W-1:0]             arr_rdata
);
  localparam int LANE_W  = $clog2(LANES);
  localparam int WADDR_W = ADDR_W - LANE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rmw_state_e          state_q, state_d;
  logic [WADDR_W-1:0]  waddr_q;
  logic [LANE_W-1:0]   lane_q;
  logic                write_q;
  logic [LANES-1:0]    mask_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [CW_W-1:0]     cw_q;
  logic                rsp_valid_q;
  logic [BYTE_W-1:0]   rsp_data_q;

  logic                accept, full_mask;
  logic                cap_en, cw_en, rsp_en;
  logic [DATA_W-1:0]   fixed_data, merged_data, enc_in;
  logic [CW_W-1:0]     enc_cw;

  ecc_corrector u_corr (.cw_i(arr_rdata), .data_o(fixed_data));
  lane_merge    u_merge (.mask_i(mask_q), .new_i(wdata_q), .old_i(fixed_data), .merged_o(merged_data));
  ecc_encoder   u_enc (.data_i(enc_in), .cw_o(enc_cw));

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign full_mask = &req_mask;
  assign enc_in    = (state_q == ST_FIX) ? merged_data : req_wdata;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = (req_write && full_mask) ? ST_WRITE : ST_READ;
      ST_READ:  state_d = ST_FIX;
      ST_FIX:   state_d = write_q ? ST_WRITE : ST_IDLE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign cap_en = accept;
  assign cw_en  = (accept && req_write && full_mask) || ((state_q == ST_FIX) && write_q);
  assign rsp_en = (state_q == ST_FIX) && !write_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_en;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      waddr_q <= req_addr[ADDR_W-1:LANE_W];
      lane_q  <= req_addr[LANE_W-1:0];
      write_q <= req_write;
      mask_q  <= req_mask;
      wdata_q <= req_wdata;
    end
    if (cw_en)  cw_q       <= enc_cw;
    if (rsp_en) rsp_data_q <= fixed_data[BYTE_W*lane_q +: BYTE_W];
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign arr_en    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign arr_we    = (state_q == ST_WRITE);
  assign arr_addr  = waddr_q;
  assign arr_wdata = cw_q;
endmodule

// File: rtl/ecc_rmw_chk.sv
module ecc_rmw_chk
  import ecc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [LANES-1:0]  req_mask,
  input logic              rsp_valid,
  input logic              arr_en,
  input logic              arr_we,
  input logic [CW_W-1:0]   arr_wdata
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R3
  full_write_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && (&req_mask)) |=> (arr_en && arr_we));

  // R4
  partial_reads_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !(&req_mask)) |=> (arr_en && !arr_we && !req_ready));

  // R5
  read_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> (arr_en && !arr_we && !req_ready));

  // R5
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(arr_en && !arr_we, 2));

  // R5
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  clean_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_en && arr_we) |-> (ecc_syndrome(arr_wdata) == '0));
endmodule

bind ecc_rmw_unit ecc_rmw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_mask(req_mask), .rsp_valid(rsp_valid),
  .arr_en(arr_en), .arr_we(arr_we), .arr_wdata(arr_wdata)
);

// File: tb/ecc_rmw_unit_tb.sv
module ecc_rmw_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [13:0] req_addr;
  logic [3:0]  req_mask;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        arr_en, arr_we;
  logic [11:0] arr_addr;
  logic [37:0] arr_wdata, arr_rdata;

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0;
  logic [37:0] mem [0:4095];
  logic        poke_en = 1'b0;
  logic [11:0] poke_a;
  logic [37:0] poke_d;

  always #4 clk = ~clk;

  ecc_rmw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    else if (arr_en) begin
      if (arr_we) begin mem[arr_addr] <= arr_wdata; n_wr <= n_wr + 1; end
      else begin arr_rdata <= mem[arr_addr]; n_rd <= n_rd + 1; end
    end
  end

  // reference codeword built from the R2 layout
  function automatic logic [37:0] ref_enc(input logic [31:0] d);
    logic [37:0] cw = '0;
    int j = 0;
    for (int p = 1; p <= 38; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        cw[p-1] = d[j]; j++;
      end
    for (int k = 0; k < 6; k++) begin
      logic par = 1'b0;
      for (int p = 1; p <= 38; p++) if (p[k]) par ^= cw[p-1];
      cw[(1 << k) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [31:0] ref_merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = m[l] ? n[l*8 +: 8] : o[l*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [37:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  // issue one request; observe six falling edges after acceptance
  task automatic xfer(input bit w, input logic [13:0] a, input logic [3:0] m, input logic [31:0] wd,
                      output int low, output int rsp_at, output int rsp_cnt, output logic [7:0] got,
                      output int d_rd, output int d_wr);
    int rd0, wr0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_mask = m; req_wdata = wd;
    rd0 = n_rd; wr0 = n_wr;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    low = 0; rsp_at = 0; rsp_cnt = 0; got = '0;
    for (int c = 1; c <= 6; c++) begin
      if (!req_ready) low++;
      if (rsp_valid) begin rsp_cnt++; if (rsp_at == 0) begin rsp_at = c; got = rsp_data; end end
      if (c < 6) @(negedge clk);
    end
    d_rd = n_rd - rd0; d_wr = n_wr - wr0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int low, rat, rcnt, drd, dwr;
    logic [7:0] got;
    logic [31:0] base, nw, exp_d;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_mask = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && arr_en == 1'b0, "R1 reset outputs",
          {req_ready, rsp_valid, arr_en}, 3'b100);

    // R3 and R2: full writes at several words, including both address ends
    for (int t = 0; t < 3; t++) begin
      logic [11:0] wa;
      wa   = (t == 0) ? 12'd5 : (t == 1) ? 12'd0 : 12'hfff;
      base = 32'hA5C3_0F71 ^ {wa, wa, 8'h3C};
      xfer(1'b1, {wa, 2'b00}, 4'hF, base, low, rat, rcnt, got, drd, dwr);
      check(low == 1, "R3 ready low cycles", low, 1);
      check(drd == 0 && dwr == 1, "R3 array access count", {drd[7:0], dwr[7:0]}, 16'h0001);
      check(mem[wa] == ref_enc(base), "R2 stored codeword layout", mem[wa], ref_enc(base));
      // R5: every lane read back
      for (int l = 0; l < 4; l++) begin
        xfer(1'b0, {wa, 2'(l)}, 4'h0, 32'h0, low, rat, rcnt, got, drd, dwr);
        check(rat == 3 && rcnt == 1, "R5 response timing", {rat[7:0], rcnt[7:0]}, 16'h0301);
        check(got == base[l*8 +: 8], "R5 read byte", got, base[l*8 +: 8]);
        check(low == 2 && drd == 1 && dwr == 0, "R5 ready and access count",
              {low[7:0], drd[7:0], dwr[7:0]}, 24'h020100);
      end
    end

    // R6 / R7: every single-bit flip, every lane
    base = 32'h3C96_E15A;
    for (int b = 0; b < 38; b++) begin
      bit is_chk;
      is_chk = (b == 0 || b == 1 || b == 3 || b == 7 || b == 15 || b == 31);
      poke(12'd77, ref_enc(base) ^ (38'd1 << b));
      for (int l = 0; l < 4; l++) begin
        xfer(1'b0, {12'd77, 2'(l)}, 4'h0, 32'h0, low, rat, rcnt, got, drd, dwr);
        if (is_chk) check(got == base[l*8 +: 8], "R7 check-bit flip ignored", got, base[l*8 +: 8]);
        else        check(got == base[l*8 +: 8], "R6 data-bit flip corrected", got, base[l*8 +: 8]);
      end
    end

    // R4 / R9: every partial mask on a clean word
    base = 32'h1122_3344; nw = 32'hDEAD_BEEF;
    for (int m = 0; m < 15; m++) begin
      poke(12'd300, ref_enc(base));
      xfer(1'b1, {12'd300, 2'b01}, 4'(m), nw, low, rat, rcnt, got, drd, dwr);
      exp_d = ref_merge(base, nw, 4'(m));
      if (m == 0) check(mem[12'd300] == ref_enc(base), "R9 empty mask rewrite", mem[12'd300], ref_enc(base));
      else        check(mem[12'd300] == ref_enc(exp_d), "R4 merged word", mem[12'd300], ref_enc(exp_d));
      check(low == 3 && drd == 1 && dwr == 1 && rcnt == 0, "R4 ready and access count",
            {low[7:0], drd[7:0], dwr[7:0], rcnt[7:0]}, 32'h03010100);
    end

    // R8: partial write over a word with a latent single-bit error
    base = 32'h0F0F_5AA5; nw = 32'h7788_99AA;
    for (int b = 0; b < 38; b++) begin
      poke(12'd1234, ref_enc(base) ^ (38'd1 << b));
      xfer(1'b1, {12'd1234, 2'b10}, 4'b0101, nw, low, rat, rcnt, got, drd, dwr);
      exp_d = ref_merge(base, nw, 4'b0101);
      check(mem[12'd1234] == ref_enc(exp_d), "R8 scrubbed write-back", mem[12'd1234], ref_enc(exp_d));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule